// File: doc/BRIEF.md
# Parallel Configuration Loader

This block is a hardware master that pushes a configuration image into a target programmable device through a byte-wide parallel slave port. A single start pulse, together with the number of bytes to send, launches a load. The block first pulses the device's program line, waits for the device to finish clearing itself, then opens the port (write enable and select) and clocks each byte from an upstream valid/ready stream onto the data pins, one configuration clock pulse per byte. Bytes are taken from the stream only when the port is ready for them, so the source may pause at any time.

After the last byte the port is closed, select first and write enable one cycle later, and the block keeps toggling the configuration clock until the device raises its done line. Every wait (device clear, busy stall, done) is bounded by a cycle-count timeout; on expiry the load is aborted, the pins are released, and a code naming the failing stage is reported. When the optional busy check is selected, a byte clocked while the device signals busy is re-clocked unchanged until busy drops. The configuration clock half-period, program pulse width and timeout are parameters in system clock cycles.

Top module: `cfgld_loader`

## Requirements
- R1: Out of reset the program, select and write-enable pins are low, the configuration clock is high, the data pins are zero, the stream ready, done pulse and abort are low and the error code is 0.
- R2: A start pulse in the idle state drives the program pin high for exactly PROG_CYC system cycles, once; a start pulse while a load is running has no effect (no second program pulse and a single done pulse for that load).
- R3: Select and write enable stay low until, after the program pulse, the init input and the busy input are both seen low; both are then raised together while the configuration clock is high, and the program pin is never high while select is high.
- R4: Each byte taken from the stream is presented on the data pins while the configuration clock goes low for HALF_CYC cycles and then high for HALF_CYC cycles; the data is unchanged at the rising edge, bytes appear in stream order, and exactly byte_count_i bytes are consumed.
- R5: Stream ready is high only while the port is open (select high) with the configuration clock high and the block waits for the next byte; no clock pulse is issued while the source withholds data.
- R6: With busy checking selected, if busy is high at the end of a byte's high phase, the same byte is clocked again, once per such check, until busy is seen low.
- R7: With busy checking not selected, the busy input is ignored during data transfer: one clock pulse per byte.
- R8: After the last byte select falls while write enable is still high, and write enable falls exactly one system cycle later.
- R9: After the port is closed the block issues configuration clock pulses while done is low and issues none once done is seen high; if done is already high, no pulse is issued.
- R10: A wait longer than TIMEOUT_CYC cycles ends the load with error code 1 (device clear wait), 2 (busy stall) or 3 (done wait), a one-cycle abort pulse coinciding with the done pulse, select and write enable low; the code holds until the next start.
- R11: Every load ends with a done pulse of exactly one cycle; a successful load reports error code 0.
- R12: A load with byte_count_i of zero opens and closes the port without any data clock pulse and still waits for done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse for a load |
| byte_count_i | input | CNT_W | Number of bytes in the load, sampled with start |
| busy_check_i | input | 1 | Selects busy-stall handling, sampled with start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | DATA_W | Stream byte |
| s_ready_o | output | 1 | Stream ready |
| cfg_prog_o | output | 1 | Device program/clear request, active high |
| cfg_cs_o | output | 1 | Port select, active high |
| cfg_wr_o | output | 1 | Port write enable, active high |
| cfg_clk_o | output | 1 | Configuration clock, idles high |
| cfg_data_o | output | DATA_W | Configuration data pins |
| cfg_init_i | input | 1 | Device still clearing, active high |
| cfg_busy_i | input | 1 | Device busy, active high |
| cfg_done_i | input | 1 | Device configured, active high |
| load_done_o | output | 1 | One-cycle pulse at the end of every load |
| abort_o | output | 1 | One-cycle pulse when a load is aborted |
| err_code_o | output | 2 | 0 ok, 1 clear timeout, 2 busy timeout, 3 done timeout |

## Verification
A corrupted control state shows at the pins within one configuration clock half-period: a wrong phase count stretches or shortens the clock pulses the target model measures, a wrong byte counter makes the stream consume too many or too few bytes so the scoreboard is left with leftovers or underflows, and a wrong busy or done decision changes the number of extra clock pulses counted before the done pulse. A wrong wait timer is seen only at the end of a stalled stage, as a missing or wrong error code in the done cycle, so each of the three timeouts is driven to expiry and each stall length is counted edge by edge.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WINIT,
    ST_SETUP,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_RELCS,
    ST_RELWR,
    ST_DCHK,
    ST_DLOW,
    ST_DHIGH,
    ST_OK,
    ST_FAIL
  } ld_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_INIT = 2'd1,
    ERR_BUSY = 2'd2,
    ERR_DONE = 2'd3
  } ld_err_e;

endpackage

// File: rtl/cfgld_phase.sv
// Counts the system cycles of one configuration clock half-period.
module cfgld_phase #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int W = (HALF < 2) ? 1 : $clog2(HALF);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign last_o = run_i && (cnt_q == W'(HALF - 1));
  assign cnt_en = 1'b1;

  always_comb begin
    if (!run_i || last_o) cnt_d = '0;
    else                  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: a half-period never runs past HALF cycles
  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < HALF);

endmodule

// File: rtl/cfgld_timeout.sv
// Saturating cycle counter with clear; expired once LIMIT cycles were counted.
module cfgld_timeout #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired_o = (cnt_q == W'(LIMIT));
  assign cnt_en    = clr_i || (en_i && !expired_o);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10: the wait counter saturates at its limit
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= LIMIT);

endmodule

// File: rtl/cfgld_fsm.sv
// Load sequencer: program pulse, clear wait, byte clocking, close, done wait.
module cfgld_fsm
  import cfgld_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              busy_check_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              cfg_prog_o,
  output logic              cfg_cs_o,
  output logic              cfg_wr_o,
  output logic              cfg_clk_o,
  output logic [DATA_W-1:0] cfg_data_o,
  input  logic              cfg_init_i,
  input  logic              cfg_busy_i,
  input  logic              cfg_done_i,
  input  logic              phase_last_i,
  input  logic              hold_exp_i,
  input  logic              wait_exp_i,
  output logic              phase_run_o,
  output logic              hold_en_o,
  output logic              hold_clr_o,
  output logic              wait_en_o,
  output logic              wait_clr_o,
  output logic              load_done_o,
  output logic              abort_o,
  output logic [1:0]        err_code_o
);

  ld_state_e          state_q, state_d;
  logic [CNT_W-1:0]   remain_q, remain_d;
  logic [DATA_W-1:0]  data_q;
  logic               retry_q, retry_d;
  logic               chk_q, chk_d;
  ld_err_e            err_q, err_d;
  logic               data_en, remain_en, accept_start;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign data_en      = (state_q == ST_FETCH) && s_valid_i;
  assign remain_en    = data_en || accept_start;

  always_comb begin
    if (accept_start) remain_d = byte_count_i;
    else              remain_d = remain_q - CNT_W'(1);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    retry_d = retry_q;
    chk_d   = chk_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PROG;
          chk_d   = busy_check_i;
          err_d   = ERR_NONE;
          retry_d = 1'b0;
        end
      end
      ST_PROG: begin
        if (hold_exp_i) state_d = ST_WINIT;
      end
      ST_WINIT: begin
        if (!cfg_init_i && !cfg_busy_i) begin
          state_d = ST_SETUP;
        end else if (wait_exp_i) begin
          state_d = ST_FAIL;
          err_d   = ERR_INIT;
        end
      end
      ST_SETUP: begin
        state_d = (remain_q == '0) ? ST_RELCS : ST_FETCH;
      end
      ST_FETCH: begin
        if (s_valid_i) begin
          state_d = ST_LOW;
          retry_d = 1'b0;
        end
      end
      ST_LOW: begin
        if (retry_q && wait_exp_i) begin
          state_d = ST_FAIL;
          err_d   = ERR_BUSY;
        end else if (phase_last_i) begin
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (retry_q && wait_exp_i) begin
          state_d = ST_FAIL;
          err_d   = ERR_BUSY;
        end else if (phase_last_i) begin
          if (chk_q && cfg_busy_i) begin
            state_d = ST_LOW;
            retry_d = 1'b1;
          end else if (remain_q == '0) begin
            state_d = ST_RELCS;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_RELCS: state_d = ST_RELWR;
      ST_RELWR: state_d = ST_DCHK;
      ST_DCHK: begin
        if (cfg_done_i) begin
          state_d = ST_OK;
        end else if (wait_exp_i) begin
          state_d = ST_FAIL;
          err_d   = ERR_DONE;
        end else begin
          state_d = ST_DLOW;
        end
      end
      ST_DLOW: begin
        if (phase_last_i) state_d = ST_DHIGH;
      end
      ST_DHIGH: begin
        if (phase_last_i) state_d = ST_DCHK;
      end
      ST_OK:   state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      data_q   <= '0;
      retry_q  <= 1'b0;
      chk_q    <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
      chk_q   <= chk_d;
      err_q   <= err_d;
      if (remain_en) remain_q <= remain_d;
      if (data_en)   data_q   <= s_data_i;
    end
  end

  // pin and control decode
  always_comb begin
    cfg_prog_o  = (state_q == ST_PROG);
    cfg_cs_o    = (state_q inside {ST_SETUP, ST_FETCH, ST_LOW, ST_HIGH});
    cfg_wr_o    = (state_q inside {ST_SETUP, ST_FETCH, ST_LOW, ST_HIGH, ST_RELCS});
    cfg_clk_o   = !(state_q inside {ST_LOW, ST_DLOW});
    cfg_data_o  = data_q;
    s_ready_o   = (state_q == ST_FETCH);
    phase_run_o = (state_q inside {ST_LOW, ST_HIGH, ST_DLOW, ST_DHIGH});
    hold_en_o   = (state_q == ST_PROG);
    hold_clr_o  = (state_q != ST_PROG);
    wait_clr_o  = (state_q inside {ST_IDLE, ST_PROG, ST_SETUP, ST_FETCH, ST_RELCS, ST_RELWR});
    wait_en_o   = (state_q inside {ST_WINIT, ST_DCHK, ST_DLOW, ST_DHIGH}) ||
                  (retry_q && (state_q inside {ST_LOW, ST_HIGH}));
    load_done_o = (state_q inside {ST_OK, ST_FAIL});
    abort_o     = (state_q == ST_FAIL);
    err_code_o  = err_q;
  end

  // R4: the byte on the pins does not change at a rising configuration clock edge
  assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_clk_o) && cfg_cs_o) |-> $stable(cfg_data_o));

  // R8: select is released while write enable is still high
  assert_cs_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_cs_o) && (err_q == ERR_NONE) |-> cfg_wr_o);

  // R3: program and select never overlap
  assert_no_prog_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_prog_o && cfg_cs_o));

  // R11: done lasts a single cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_done_o |=> !load_done_o);

  // R10: an abort always carries a failure code
  assert_abort_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (err_code_o != 2'd0));

endmodule

// File: rtl/cfgld_loader.sv
// Top: reset release, phase timer, program-hold timer, wait timer, sequencer.
module cfgld_loader #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int HALF_CYC    = 2,
  parameter int TIMEOUT_CYC = 500000,
  parameter int PROG_CYC    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              busy_check_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              cfg_prog_o,
  output logic              cfg_cs_o,
  output logic              cfg_wr_o,
  output logic              cfg_clk_o,
  output logic [DATA_W-1:0] cfg_data_o,
  input  logic              cfg_init_i,
  input  logic              cfg_busy_i,
  input  logic              cfg_done_i,
  output logic              load_done_o,
  output logic              abort_o,
  output logic [1:0]        err_code_o
);
  localparam int HOLD_LIMIT = (PROG_CYC < 1) ? 0 : PROG_CYC - 1;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic phase_run, phase_last;
  logic hold_en, hold_clr, hold_exp;
  logic wait_en, wait_clr, wait_exp;

  cfgld_phase #(.HALF(HALF_CYC)) u_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (phase_run),
    .last_o (phase_last)
  );

  cfgld_timeout #(.LIMIT(HOLD_LIMIT)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (hold_clr),
    .en_i      (hold_en),
    .expired_o (hold_exp)
  );

  cfgld_timeout #(.LIMIT(TIMEOUT_CYC)) u_wait (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (wait_clr),
    .en_i      (wait_en),
    .expired_o (wait_exp)
  );

  cfgld_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .byte_count_i (byte_count_i),
    .busy_check_i (busy_check_i),
    .s_valid_i    (s_valid_i),
    .s_data_i     (s_data_i),
    .s_ready_o    (s_ready_o),
    .cfg_prog_o   (cfg_prog_o),
    .cfg_cs_o     (cfg_cs_o),
    .cfg_wr_o     (cfg_wr_o),
    .cfg_clk_o    (cfg_clk_o),
    .cfg_data_o   (cfg_data_o),
    .cfg_init_i   (cfg_init_i),
    .cfg_busy_i   (cfg_busy_i),
    .cfg_done_i   (cfg_done_i),
    .phase_last_i (phase_last),
    .hold_exp_i   (hold_exp),
    .wait_exp_i   (wait_exp),
    .phase_run_o  (phase_run),
    .hold_en_o    (hold_en),
    .hold_clr_o   (hold_clr),
    .wait_en_o    (wait_en),
    .wait_clr_o   (wait_clr),
    .load_done_o  (load_done_o),
    .abort_o      (abort_o),
    .err_code_o   (err_code_o)
  );

endmodule

// File: tb/tb_cfgld_loader.sv
module tb_cfgld_loader;
  localparam int CNT_W = 8;
  localparam int DW    = 8;
  localparam int HALF  = 2;
  localparam int TMO   = 300;
  localparam int PH    = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CNT_W-1:0] bcount = '0;
  logic          bchk = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          init_i = 1'b0;
  logic          busy_i = 1'b0;
  logic          done_i = 1'b0;
  logic          s_ready, prog, cs, wr, cclk, load_done, abort;
  logic [DW-1:0] cdata;
  logic [1:0]    err;

  cfgld_loader #(.CNT_W(CNT_W), .DATA_W(DW), .HALF_CYC(HALF),
                 .TIMEOUT_CYC(TMO), .PROG_CYC(PH)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(bcount),
    .busy_check_i(bchk), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_ready_o(s_ready), .cfg_prog_o(prog), .cfg_cs_o(cs), .cfg_wr_o(wr),
    .cfg_clk_o(cclk), .cfg_data_o(cdata), .cfg_init_i(init_i),
    .cfg_busy_i(busy_i), .cfg_done_i(done_i), .load_done_o(load_done),
    .abort_o(abort), .err_code_o(err));

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model configuration
  int m_init_delay = 3, m_busy_after = -1, m_busy_len = 0, m_done_extra = 0;
  bit m_bchk = 0, m_expect_ok = 1;
  // observation state
  int edges = 0, repeats = 0, post_edges = 0, prog_pulses = 0, dones = 0, aborts = 0;
  int last_err = 0, prog_w = 0, done_w = 0, init_cnt = 0, busy_left = 0;
  bit load_over = 0, in_post = 0, wr_chk = 0, prev_clk = 1, prev_cs = 0, was_busy;
  logic [DW-1:0] last_data = '0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] e;

  // monitor and target model, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prog) prog_w++;
      else if (prog_w > 0) begin
        check(prog_w == PH, "R2 program width", prog_w, PH);
        prog_pulses++;
        prog_w = 0;
      end
      if (prog) begin
        init_i = 1'b1;
        init_cnt = 0;
      end else if (init_i && m_init_delay >= 0) begin
        init_cnt++;
        if (init_cnt >= m_init_delay) init_i = 1'b0;
      end
      if (cs && init_i) check(0, "R3 select during clear", 1, 0);
      if (s_ready && (!cs || !cclk)) check(0, "R5 ready outside open port", 1, 0);
      if (cclk && !prev_clk && cs) begin
        was_busy = busy_i;
        if (was_busy && busy_left > 0) busy_left--;
        if (was_busy && m_bchk) begin
          repeats++;
          check(cdata == last_data, "R6 repeated byte", int'(cdata), int'(last_data));
        end else begin
          edges++;
          if (exp_q.size() == 0) check(0, "R4 byte without stream item", int'(cdata), -1);
          else begin
            e = exp_q.pop_front();
            check(cdata == e, "R4 byte order", int'(cdata), int'(e));
          end
          last_data = cdata;
          if (edges == m_busy_after) busy_left = m_busy_len;
        end
        busy_i = (busy_left > 0);
      end
      if (cclk && !prev_clk && !cs && in_post) begin
        post_edges++;
        if (m_done_extra >= 0 && post_edges >= m_done_extra) done_i = 1'b1;
      end
      if (cs && !prev_cs)
        check(wr && cclk && !init_i && !busy_i, "R3 port opening", int'({wr, cclk, init_i, busy_i}), 4'b1100);
      if (!cs && prev_cs) begin
        in_post = 1;
        if (m_expect_ok) check(wr == 1'b1, "R8 select before write", int'(wr), 1);
        wr_chk = m_expect_ok;
        if (m_done_extra == 0) done_i = 1'b1;
      end else if (wr_chk) begin
        check(wr == 1'b0, "R8 write release one cycle later", int'(wr), 0);
        wr_chk = 0;
      end
      if (load_done) begin
        done_w++;
        if (done_w == 1) begin
          dones++;
          last_err = int'(err);
          if (abort) aborts++;
          load_over = 1;
        end
      end else if (done_w > 0) begin
        check(done_w == 1, "R11 done pulse width", done_w, 1);
        done_w = 0;
      end
      if (abort && !load_done) check(0, "R10 abort without done", 1, 0);
      prev_clk = cclk;
      prev_cs  = cs;
    end
  end

  // driver: configures the target, feeds the stream, waits for the end
  task automatic run_load(input int n, input int gap, input bit chk, input int idel,
                          input int bafter, input int blen, input int dext,
                          input int exp_err, input int restart_at, input int seed);
    @(negedge clk);
    m_init_delay = idel; m_busy_after = bafter; m_busy_len = blen;
    m_done_extra = dext; m_bchk = chk; m_expect_ok = (exp_err == 0);
    edges = 0; repeats = 0; post_edges = 0; prog_pulses = 0; dones = 0; aborts = 0;
    load_over = 0; in_post = 0; busy_left = 0; busy_i = 1'b0; done_i = 1'b0;
    exp_q.delete();
    bcount = CNT_W'(n); bchk = chk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (load_over) break;
      s_valid = 1'b1;
      s_data = DW'(i * 37 + seed);
      while (!s_ready && !load_over) @(negedge clk);
      if (load_over) break;
      exp_q.push_back(s_data);
      @(negedge clk);
      s_valid = 1'b0;
      if (i == restart_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (gap) @(negedge clk);
    end
    s_valid = 1'b0;
    while (!load_over) @(negedge clk);
    repeat (8) @(negedge clk);
    check(dones == 1, "R11 one done per load", dones, 1);
    check(last_err == exp_err, "R10 R11 error code at done", last_err, exp_err);
    check(int'(err) == exp_err, "R10 error code held", int'(err), exp_err);
    check(aborts == (exp_err != 0 ? 1 : 0), "R10 abort with failure", aborts, exp_err != 0 ? 1 : 0);
    check(prog_pulses == 1, "R2 single program pulse", prog_pulses, 1);
    check(!cs && !wr, "R10 pins released", int'({cs, wr}), 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check({prog, cs, wr, cclk} == 4'b0001, "R1 pins after reset", int'({prog, cs, wr, cclk}), 1);
    check(cdata == '0 && !s_ready && !load_done && !abort && err == 2'd0,
          "R1 status after reset", int'({cdata, s_ready, load_done, abort, err}), 0);

    // R4 R9 basic load with three extra clocks before done
    run_load(6, 0, 1, 5, -1, 0, 3, 0, -1, 11);
    check(edges == 6 && exp_q.size() == 0, "R4 all bytes clocked", edges, 6);
    check(post_edges == 3, "R9 extra clocks until done", post_edges, 3);

    // R5 source with gaps
    run_load(5, 3, 1, 2, -1, 0, 1, 0, -1, 90);
    check(edges == 5 && exp_q.size() == 0, "R5 gapped stream", edges, 5);

    // R6 busy stall with checking selected
    run_load(6, 0, 1, 4, 3, 4, 2, 0, -1, 5);
    check(repeats == 4, "R6 byte re-clocked while busy", repeats, 4);
    check(edges == 6 && exp_q.size() == 0, "R6 stream complete after stall", edges, 6);

    // R7 busy ignored when checking not selected
    run_load(5, 1, 0, 3, 2, 3, 1, 0, -1, 200);
    check(repeats == 0 && edges == 5, "R7 one pulse per byte", edges + 100 * repeats, 5);

    // R9 done already high at close
    run_load(3, 0, 1, 1, -1, 0, 0, 0, -1, 17);
    check(post_edges == 0, "R9 no extra clocks when done", post_edges, 0);

    // R12 empty load
    run_load(0, 0, 1, 2, -1, 0, 2, 0, -1, 0);
    check(edges == 0, "R12 no data pulses", edges, 0);
    check(post_edges == 2, "R12 done wait still runs", post_edges, 2);

    // R10 clear-wait timeout
    run_load(4, 0, 1, -1, -1, 0, 0, 1, -1, 3);
    check(edges == 0, "R10 port never opened", edges, 0);

    // R10 busy stall timeout
    run_load(4, 0, 1, 2, 2, 1000000, 0, 2, -1, 44);

    // R10 done-wait timeout
    run_load(2, 0, 1, 2, -1, 0, -1, 3, -1, 61);
    check(post_edges > 0, "R10 clocks issued before done timeout", post_edges, 1);

    // R2 start during a load is ignored; R11 code back to zero after failure
    run_load(8, 0, 1, 3, -1, 0, 1, 0, 2, 123);
    check(edges == 8 && exp_q.size() == 0, "R2 load unaffected by second start", edges, 8);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule